// File: doc/BRIEF.md
# Cache Control Register with Instruction-Cache Index Mapping

This block holds a 32-bit cache control word that software writes and reads as a whole longword. The stored bits drive the cache configuration outputs: the direct-mapped or double-size mode select, the instruction-cache and operand-cache enables, the operand-cache index mode, the operand-cache RAM mode, and the copy-back and write-through write modes. Reserved positions are never stored and always read back as zero.

The block also contains the valid bits of a 256-entry instruction cache. A lookup port turns an effective address into an entry index in the same cycle and returns that entry's valid bit. The index comes from one of two address-bit mappings, chosen by a stored control bit. A fill port marks one entry valid. Two command bits act on write only: one clears every instruction-cache valid bit at once, the other sends a one-cycle operand-cache invalidate pulse. Both always read back as zero.

Top module: `ccr_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00000000, every configuration output is 0, and every valid bit reads 0 through the lookup port.
- R2: A write with wr_en high stores wr_data bits 31, 15, 8, 7, 5, 2, 1 and 0. The stored value appears on rd_data from the cycle after the write edge.
- R3: Bits 30..16, 14..12, 10, 9, 6 and 4 are never stored. Writing 0xFFFFFFFF reads back as 0x800081A7.
- R4: A write with bit 11 set drives ic_inv_pulse high during that write cycle only. Bit 11 reads back as 0.
- R5: A write with bit 3 set drives oc_inv_pulse high during that write cycle only. Bit 3 reads back as 0.
- R6: Configuration outputs follow the stored bits: dbl_mode=bit 31, ic_en=bit 8, oc_idx_mode=bit 7, oc_ram_mode=bit 5, copy_back=bit 2, write_thru=bit 1, oc_en=bit 0.
- R7: With stored bit 15 at 0, lk_index equals lk_addr[12:5].
- R8: With stored bit 15 at 1, lk_index equals {lk_addr[25], lk_addr[11:5]}.
- R9: fill_en high at a clock edge sets the valid bit of fill_index. lk_valid returns the valid bit of lk_index in the same cycle.
- R10: A write with bit 11 set clears all 256 valid bits at that clock edge. The clear wins over a fill in the same cycle.
- R11: While wr_en is low, the stored register value does not change.
- R12: A change of bit 15 affects the lookup in the first cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Longword write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read-back value |
| dbl_mode | output | 1 | 1 = double-size cache mode |
| ic_en | output | 1 | Instruction-cache enable |
| ic_idx_mode | output | 1 | Instruction-cache index mode |
| oc_idx_mode | output | 1 | Operand-cache index mode |
| oc_ram_mode | output | 1 | Operand-cache RAM mode |
| copy_back | output | 1 | Copy-back write mode |
| write_thru | output | 1 | Write-through mode |
| oc_en | output | 1 | Operand-cache enable |
| ic_inv_pulse | output | 1 | Instruction-cache invalidate-all pulse |
| oc_inv_pulse | output | 1 | Operand-cache invalidate pulse |
| lk_addr | input | 32 | Lookup effective address |
| lk_index | output | 8 | Computed entry index |
| lk_valid | output | 1 | Valid bit of the looked-up entry |
| fill_en | input | 1 | Set one valid bit |
| fill_index | input | 8 | Entry to mark valid |

## Verification
The assertions assume that wr_en, wr_data, fill_en and fill_index are settled before each rising edge and are never X or Z after reset. They also assume that one clock edge is the whole effect of a write. The stimulus changes all inputs only on falling edges and always drives defined values. The bench makes simultaneous fills and invalidates on purpose, so the clear-priority property is exercised rather than avoided.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned POS_DBL    = 31;
  localparam int unsigned POS_ICIDX  = 15;
  localparam int unsigned POS_ICINV  = 11;
  localparam int unsigned POS_ICEN   = 8;
  localparam int unsigned POS_OCIDX  = 7;
  localparam int unsigned POS_OCRAM  = 5;
  localparam int unsigned POS_OCINV  = 3;
  localparam int unsigned POS_CB     = 2;
  localparam int unsigned POS_WT     = 1;
  localparam int unsigned POS_OCEN   = 0;

  localparam logic [REG_W-1:0] STORE_MASK =
      (REG_W'(1) << POS_DBL)   | (REG_W'(1) << POS_ICIDX) |
      (REG_W'(1) << POS_ICEN)  | (REG_W'(1) << POS_OCIDX) |
      (REG_W'(1) << POS_OCRAM) | (REG_W'(1) << POS_CB)    |
      (REG_W'(1) << POS_WT)    | (REG_W'(1) << POS_OCEN);

  typedef struct packed {
    logic dbl_mode;
    logic ic_idx_mode;
    logic ic_en;
    logic oc_idx_mode;
    logic oc_ram_mode;
    logic copy_back;
    logic write_thru;
    logic oc_en;
  } cfg_t;
endpackage

// File: rtl/ccr_regfile.sv
module ccr_regfile
  import ccr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output cfg_t             cfg,
  output logic             ic_inv,
  output logic             oc_inv
);
  logic [REG_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (wr_en) word_d = wr_data & STORE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign rd_data = word_q;
  assign ic_inv  = wr_en & wr_data[POS_ICINV];
  assign oc_inv  = wr_en & wr_data[POS_OCINV];

  always_comb begin
    cfg.dbl_mode    = word_q[POS_DBL];
    cfg.ic_idx_mode = word_q[POS_ICIDX];
    cfg.ic_en       = word_q[POS_ICEN];
    cfg.oc_idx_mode = word_q[POS_OCIDX];
    cfg.oc_ram_mode = word_q[POS_OCRAM];
    cfg.copy_back   = word_q[POS_CB];
    cfg.write_thru  = word_q[POS_WT];
    cfg.oc_en       = word_q[POS_OCEN];
  end

  // R2 R3 R4 R5
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & 32'h8000_81A7));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/ccr_index_map.sv
module ccr_index_map #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned LINE_LSB = 5,
  parameter int unsigned ALT_BIT  = 25
) (
  input  logic              alt_mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned TOP = LINE_LSB + IDX_W - 1;

  logic [IDX_W-1:0] plain_idx, alt_idx;
  logic unused_addr_bits;

  assign plain_idx = addr[TOP:LINE_LSB];
  assign alt_idx   = {addr[ALT_BIT], addr[TOP-1:LINE_LSB]};
  assign idx       = alt_mode ? alt_idx : plain_idx;
  assign unused_addr_bits = ^addr;
endmodule

// File: rtl/ccr_valid_array.sv
module ccr_valid_array #(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);
  logic [DEPTH-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (fill_en) vld_d[fill_idx] = 1'b1;
    if (inv_all) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_valid = vld_q[rd_idx];

  // R10
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_q == '0));

  // R9
  fill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_all) |=> vld_q[$past(fill_idx)]);
endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned LINE_LSB = 5,
  parameter int unsigned ALT_BIT  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              dbl_mode,
  output logic              ic_en,
  output logic              ic_idx_mode,
  output logic              oc_idx_mode,
  output logic              oc_ram_mode,
  output logic              copy_back,
  output logic              write_thru,
  output logic              oc_en,
  output logic              ic_inv_pulse,
  output logic              oc_inv_pulse,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [IDX_W-1:0]  lk_index,
  output logic              lk_valid,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_index
);
  cfg_t cfg;
  logic ic_inv;

  ccr_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .cfg     (cfg),
    .ic_inv  (ic_inv),
    .oc_inv  (oc_inv_pulse)
  );

  ccr_index_map #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINE_LSB(LINE_LSB), .ALT_BIT(ALT_BIT)
  ) u_map (
    .alt_mode (cfg.ic_idx_mode),
    .addr     (lk_addr),
    .idx      (lk_index)
  );

  ccr_valid_array #(.IDX_W(IDX_W)) u_vld (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv_all  (ic_inv),
    .fill_en  (fill_en),
    .fill_idx (fill_index),
    .rd_idx   (lk_index),
    .rd_valid (lk_valid)
  );

  assign ic_inv_pulse = ic_inv;
  assign dbl_mode     = cfg.dbl_mode;
  assign ic_en        = cfg.ic_en;
  assign ic_idx_mode  = cfg.ic_idx_mode;
  assign oc_idx_mode  = cfg.oc_idx_mode;
  assign oc_ram_mode  = cfg.oc_ram_mode;
  assign copy_back    = cfg.copy_back;
  assign write_thru   = cfg.write_thru;
  assign oc_en        = cfg.oc_en;

  // R4 R5
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_inv_pulse || oc_inv_pulse) |-> wr_en);
endmodule

// File: tb/ccr_ctrl_bench.sv
module ccr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic dbl_mode, ic_en, ic_idx_mode, oc_idx_mode, oc_ram_mode;
  logic copy_back, write_thru, oc_en, ic_inv_pulse, oc_inv_pulse;
  logic [31:0] lk_addr;
  logic [7:0]  lk_index;
  logic        lk_valid;
  logic        fill_en;
  logic [7:0]  fill_index;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ccr_ctrl u_ccr_ctrl (.*);

  // {index mode, address, expected index}
  localparam logic [40:0] VECS [0:6] = '{
    {1'b0, 32'h0000_1FE0, 8'hFF},
    {1'b0, 32'h0000_0020, 8'h01},
    {1'b0, 32'h0200_1000, 8'h80},
    {1'b1, 32'h0200_0000, 8'h80},
    {1'b1, 32'h0000_1000, 8'h00},
    {1'b1, 32'h0200_0FE0, 8'hFF},
    {1'b1, 32'h0000_0AA0, 8'h55}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_fill(input logic [7:0] idx);
    @(negedge clk);
    fill_en = 1'b1; fill_index = idx;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; lk_addr = '0;
    fill_en = 1'b0; fill_index = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 outputs", {24'h0, dbl_mode, ic_en, ic_idx_mode, oc_idx_mode,
                         oc_ram_mode, copy_back, write_thru, oc_en}, 32'h0);
    for (int i = 0; i < 256; i += 37) begin
      lk_addr = 32'(i) << 5; #1;
      check("R1 valid", {31'h0, lk_valid}, 32'h0);
    end

    // R7 R8 R12 table walk: mode write, then lookup the next cycle
    for (int v = 0; v < 7; v++) begin
      do_write({16'h0, VECS[v][40], 15'h0});
      lk_addr = VECS[v][39:8]; #1;
      check(VECS[v][40] ? "R8 R12 index" : "R7 R12 index",
            {24'h0, lk_index}, {24'h0, VECS[v][7:0]});
    end

    // R2 R6 store and outputs
    do_write(32'h8000_0125);
    check("R2 readback", rd_data, 32'h8000_0125);
    check("R6 outputs", {24'h0, dbl_mode, ic_en, ic_idx_mode, oc_idx_mode,
                         oc_ram_mode, copy_back, write_thru, oc_en}, 32'h0000_00CD);
    do_write(32'h0000_8082);
    check("R6 outputs2", {24'h0, dbl_mode, ic_en, ic_idx_mode, oc_idx_mode,
                          oc_ram_mode, copy_back, write_thru, oc_en}, 32'h0000_0032);

    // R11 hold without write
    repeat (4) @(negedge clk);
    check("R11 hold", rd_data, 32'h0000_8082);

    // R3 reserved bits dropped
    do_write(32'h7FFF_7E50);
    check("R3 reserved", rd_data, 32'h0);

    // R9 fill and lookup (mode 0)
    do_fill(8'h3C);
    lk_addr = 32'h0000_0780; #1;
    check("R9 filled", {31'h0, lk_valid}, 32'h1);
    lk_addr = 32'h0000_07A0; #1;
    check("R9 neighbour", {31'h0, lk_valid}, 32'h0);
    do_fill(8'hFF);

    // R4 R10 pulse in write cycle, clear-all, clear wins over fill
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_0800; fill_en = 1'b1; fill_index = 8'h11; #1;
    check("R4 ic pulse", {30'h0, ic_inv_pulse, oc_inv_pulse}, 32'h2);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; fill_en = 1'b0; #1;
    check("R4 pulse drop", {31'h0, ic_inv_pulse}, 32'h0);
    check("R4 readback", rd_data, 32'h0);
    lk_addr = 32'h0000_0780; #1;
    check("R10 cleared", {31'h0, lk_valid}, 32'h0);
    lk_addr = 32'h0000_1FE0; #1;
    check("R10 cleared top", {31'h0, lk_valid}, 32'h0);
    lk_addr = 32'h0000_0220; #1;
    check("R10 clear beats fill", {31'h0, lk_valid}, 32'h0);

    // R5 operand invalidate pulse
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_0009; #1;
    check("R5 oc pulse", {30'h0, ic_inv_pulse, oc_inv_pulse}, 32'h1);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; #1;
    check("R5 pulse drop", {31'h0, oc_inv_pulse}, 32'h0);
    check("R5 readback", rd_data, 32'h0000_0001);

    // R3 all-ones write
    do_write(32'hFFFF_FFFF);
    check("R3 all ones", rd_data, 32'h8000_81A7);

    // R8 R9 fill then lookup in alternate mode
    do_fill(8'hAA);
    lk_addr = 32'h0200_0540; #1;
    check("R8 R9 alt lookup", {23'h0, lk_valid, lk_index}, 32'h0000_01AA);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule